// File: doc/BRIEF.md
# Serial-Port Register Front End for a Precision Voltage DAC

This block is the digital side of a high-resolution voltage-output DAC as seen through its serial port. A host shifts 24-bit frames in, most significant bit first, in SPI mode 1 (clock idles low, data changes on the rising edge and is sampled on the falling edge). Each frame holds a direction flag, a three-bit register selector and a twenty-bit payload. A frame takes effect when chip select rises, and only if exactly 24 clocks arrived while chip select was low.

Four registers sit behind the port: the pending DAC code, a control word, a clear code, and a write-only strobe register. The strobe register fires one-cycle pulses that load the pending code into the output, apply the clear code, or return the whole block to its power-up state. A register read takes two frames. The first announces the register. During the second frame, normally a no-operation write, the register's contents come back on the serial output. The SPI pins are sampled by a faster system clock through synchronizers. An active-low load pin lets a code write reach the output at once.

Top module: `dac_serial_regif`

## Requirements
- R1: A frame is 24 bits, MSB first. Bit 23 set means read and clear means write, bits 22:20 select the register, and bits 19:0 are the payload. Register 0 is a no-operation, 1 the pending code, 2 control, 3 the clear code, and 4 the strobe register. Writes to 0, 5, 6 and 7 change nothing. A write commits after chip select rises.
- R2: A frame with fewer or more than 24 falling clock edges while chip select was low changes no register, output or strobe.
- R3: After a committed read frame, the next frame returns {1, register selector, 20-bit value} on `miso`, MSB first, with a new bit after each rising clock edge. Control reads back zero-extended, and registers 0, 4, 5, 6 and 7 read as zero. Outside a pending read, `miso` shifts zeros.
- R4: Control bit 1 drives `ref_buf_sel`, bit 2 `out_clamp`, bit 3 `out_tristate`, and bit 4 `twos_comp`. Bit 0 and bits 19:10 always read back as zero.
- R5: Control bits 9:6 drive `lin_comp` and accept only 0, 1, 2, 3 and 12. A write that carries another value leaves the old compensation code in place and still updates the other bits.
- R6: While control bit 5 is set, `miso_oe` stays low. Frames are still accepted, so the bit can be cleared again. Otherwise `miso_oe` is high exactly while chip select is low.
- R7: With `ldac_n` high, a code write changes only the pending code (read back through register 1), and `dac_code` keeps its value until a load strobe (strobe register bit 0).
- R8: With `ldac_n` held low, a code write reaches `dac_code` directly.
- R9: Strobe register bit 1 copies the clear code to `dac_code`. When bits 0 and 1 are set together, the clear code wins.
- R10: Strobe register bit 2, or `rst_n` low, returns every register to its default: pending code, output code and clear code zero, control 0x00C (clamp and tristate set, all else zero), and no read pending. Reset takes priority over clear and load.
- R11: The strobe register reads as zero. Each set bit raises its own pulse (`sw_load_p` for bit 0, `sw_clear_p` for bit 1, `sw_reset_p` for bit 2) for exactly one clock per committed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select, frames the transfer |
| mosi | input | 1 | Serial data from the host |
| ldac_n | input | 1 | Active-low load: when low, code writes go straight to the output |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Drive enable for `miso` |
| dac_code | output | 20 | Code applied to the converter |
| out_clamp | output | 1 | Output clamped to ground through a resistor |
| out_tristate | output | 1 | Converter output placed in high impedance |
| ref_buf_sel | output | 1 | Reference buffer gain configuration |
| twos_comp | output | 1 | Code format select, two's complement when set |
| lin_comp | output | 4 | Linearity compensation code |
| sw_reset_p | output | 1 | One-cycle software reset pulse |
| sw_clear_p | output | 1 | One-cycle clear pulse |
| sw_load_p | output | 1 | One-cycle load pulse |

## Verification
The bench aims at frames of 23 and 25 bits. A design that commits on chip select without counting clocks would let these corrupt a register. It also pairs the two read frames and checks selectors that have no register behind them. A wrong output register or a stale pending flag there shows up as a misplaced field or leftover data on `miso`. Directed frames set clear and load together and use compensation codes just outside the legal set, where a wrong priority or a missing filter changes `dac_code` or `lin_comp`. A seeded random mix of writes, reads and strobes, with `ldac_n` toggled, is then compared against a bench model. That mix catches reset that misses a register, and strobes that last longer than one cycle or fire on a read.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;

  localparam int FRAME_W = 24;
  localparam int DATA_W  = 20;
  localparam int SEL_W   = 3;
  localparam int CTRL_W  = 10;

  typedef enum logic [SEL_W-1:0] {
    SEL_NOP  = 3'd0,
    SEL_CODE = 3'd1,
    SEL_CTRL = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_STRB = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic             rd;
    logic [SEL_W-1:0] sel;
    logic [DATA_W-1:0] data;
  } frame_t;

  // clamp (bit 2) and tristate (bit 3) set after reset
  localparam logic [CTRL_W-1:0] CTRL_DEFAULT = 10'h00C;

  function automatic logic lin_code_legal(input logic [3:0] c);
    return (c < 4'd4) || (c == 4'd12);
  endfunction

  // new control word from a write payload; illegal compensation keeps old field
  function automatic logic [CTRL_W-1:0] ctrl_merge(input logic [CTRL_W-1:0] old,
                                                   input logic [DATA_W-1:0] d);
    logic [CTRL_W-1:0] n;
    n    = d[CTRL_W-1:0];
    n[0] = 1'b0;
    if (!lin_code_legal(d[9:6])) n[9:6] = old[9:6];
    return n;
  endfunction

  // codes of narrower converters sit left-justified; low bits are dropped
  function automatic logic [DATA_W-1:0] justify(input logic [DATA_W-1:0] d,
                                                input int res_bits);
    logic [DATA_W-1:0] m;
    m = '1;
    m = m << (DATA_W - res_bits);
    return d & m;
  endfunction

endpackage

// File: rtl/dac_spi_rx.sv
module dac_spi_rx
  import dac_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               frame_stb,
  output frame_t             frame_q,
  output logic               cs_fall,
  output logic               cs_active,
  output logic               miso
);

  localparam int CNT_W = $clog2(FRAME_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [SYNC_STAGES-1:0] sclk_s, cs_s, mosi_s;
  logic sclk_d, cs_d;
  logic sclk_now, cs_now, mosi_now;
  logic sclk_rise, sclk_fall, cs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk};
      cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_n};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
      sclk_d <= sclk_now;
      cs_d   <= cs_now;
    end
  end

  always_comb begin
    sclk_now  = sclk_s[SYNC_STAGES-1];
    cs_now    = cs_s[SYNC_STAGES-1];
    mosi_now  = mosi_s[SYNC_STAGES-1];
    sclk_rise = sclk_now & ~sclk_d;
    sclk_fall = ~sclk_now & sclk_d;
    cs_fall   = ~cs_now & cs_d;
    cs_rise   = cs_now & ~cs_d;
    cs_active = ~cs_now;
  end

  logic [FRAME_W-1:0] rx_sr, tx_sr;
  logic [CNT_W-1:0]   bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr     <= '0;
      bit_cnt   <= '0;
      frame_stb <= 1'b0;
      frame_q   <= '0;
      tx_sr     <= '0;
      miso      <= 1'b0;
    end else begin
      frame_stb <= cs_rise && (bit_cnt == CNT_FULL);
      if (cs_rise) frame_q <= frame_t'(rx_sr);
      if (cs_fall) begin
        rx_sr   <= '0;
        bit_cnt <= '0;
        tx_sr   <= tx_word;
        miso    <= 1'b0;
      end else if (cs_active) begin
        if (sclk_fall) begin
          rx_sr <= {rx_sr[FRAME_W-2:0], mosi_now};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sclk_rise) begin
          miso  <= tx_sr[FRAME_W-1];
          tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  // serial output only moves on a rising serial edge or at frame start
  p_miso_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !cs_fall) |=> $stable(miso));

endmodule

// File: rtl/dac_regs.sv
module dac_regs
  import dac_regif_pkg::*;
#(
  parameter int RES_BITS = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_stb,
  input  frame_t             frame,
  input  logic               cs_fall,
  output logic [CTRL_W-1:0]  ctrl,
  output logic [DATA_W-1:0]  code_in,
  output logic [DATA_W-1:0]  clr_code,
  output logic [FRAME_W-1:0] tx_word,
  output logic               code_wr_p,
  output logic               sw_load_p,
  output logic               sw_clear_p,
  output logic               sw_reset_p
);

  logic wr_any, hit_code, hit_ctrl, hit_clr, hit_strb, do_reset;
  logic             rd_pend;
  logic [SEL_W-1:0] rd_sel;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    wr_any   = frame_stb && !frame.rd;
    hit_code = wr_any && (frame.sel == SEL_CODE);
    hit_ctrl = wr_any && (frame.sel == SEL_CTRL);
    hit_clr  = wr_any && (frame.sel == SEL_CLR);
    hit_strb = wr_any && (frame.sel == SEL_STRB);
    do_reset = hit_strb && frame.data[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= CTRL_DEFAULT;
      code_in    <= '0;
      clr_code   <= '0;
      rd_pend    <= 1'b0;
      rd_sel     <= '0;
      code_wr_p  <= 1'b0;
      sw_load_p  <= 1'b0;
      sw_clear_p <= 1'b0;
      sw_reset_p <= 1'b0;
    end else begin
      code_wr_p  <= hit_code;
      sw_load_p  <= hit_strb && frame.data[0];
      sw_clear_p <= hit_strb && frame.data[1];
      sw_reset_p <= do_reset;
      if (do_reset) begin
        ctrl     <= CTRL_DEFAULT;
        code_in  <= '0;
        clr_code <= '0;
        rd_pend  <= 1'b0;
      end else begin
        if (hit_code) code_in  <= justify(frame.data, RES_BITS);
        if (hit_ctrl) ctrl     <= ctrl_merge(ctrl, frame.data);
        if (hit_clr)  clr_code <= justify(frame.data, RES_BITS);
        if (cs_fall) rd_pend <= 1'b0;
        if (frame_stb && frame.rd) begin
          rd_pend <= 1'b1;
          rd_sel  <= frame.sel;
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CODE: rd_val = code_in;
      SEL_CTRL: rd_val = DATA_W'(ctrl);
      SEL_CLR:  rd_val = clr_code;
      default:  rd_val = '0;
    endcase
    tx_word = rd_pend ? {1'b1, rd_sel, rd_val} : '0;
  end

  // control only changes through a committed frame
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(ctrl));
  p_load_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load_p |=> !sw_load_p);
  p_clear_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear_p |=> !sw_clear_p);
  p_reset_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_p |-> (ctrl == CTRL_DEFAULT) && (code_in == '0) && (clr_code == '0));

endmodule

// File: rtl/dac_out_stage.sv
module dac_out_stage
  import dac_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] code_in,
  input  logic [DATA_W-1:0] clr_code,
  input  logic              code_wr_p,
  input  logic              ldac_low,
  input  logic              sw_load_p,
  input  logic              sw_clear_p,
  input  logic              sw_reset_p,
  output logic [DATA_W-1:0] dac_code
);

  logic take_pending;

  always_comb take_pending = sw_load_p || (code_wr_p && ldac_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dac_code <= '0;
    else if (sw_reset_p)   dac_code <= '0;
    else if (sw_clear_p)   dac_code <= clr_code;
    else if (take_pending) dac_code <= code_in;
  end

  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_reset_p && !sw_clear_p && !sw_load_p && !code_wr_p) |=> $stable(dac_code));
  p_reset_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_p |=> (dac_code == '0));
  p_clear_apply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear_p && !sw_reset_p) |=> (dac_code == $past(clr_code)));

endmodule

// File: rtl/dac_serial_regif.sv
module dac_serial_regif
  import dac_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RES_BITS    = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  input  logic        ldac_n,
  output logic        miso,
  output logic        miso_oe,
  output logic [19:0] dac_code,
  output logic        out_clamp,
  output logic        out_tristate,
  output logic        ref_buf_sel,
  output logic        twos_comp,
  output logic [3:0]  lin_comp,
  output logic        sw_reset_p,
  output logic        sw_clear_p,
  output logic        sw_load_p
);

  frame_t             frame_q;
  logic               frame_stb, cs_fall, cs_active, code_wr_p;
  logic [FRAME_W-1:0] tx_word;
  logic [CTRL_W-1:0]  ctrl;
  logic [DATA_W-1:0]  code_in, clr_code;
  logic [SYNC_STAGES-1:0] ldac_s;
  logic               ldac_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldac_s <= '1;
    else        ldac_s <= {ldac_s[SYNC_STAGES-2:0], ldac_n};
  end
  always_comb ldac_low = ~ldac_s[SYNC_STAGES-1];

  dac_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .tx_word(tx_word), .frame_stb(frame_stb), .frame_q(frame_q),
    .cs_fall(cs_fall), .cs_active(cs_active), .miso(miso)
  );

  dac_regs #(.RES_BITS(RES_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame(frame_q),
    .cs_fall(cs_fall), .ctrl(ctrl), .code_in(code_in), .clr_code(clr_code),
    .tx_word(tx_word), .code_wr_p(code_wr_p), .sw_load_p(sw_load_p),
    .sw_clear_p(sw_clear_p), .sw_reset_p(sw_reset_p)
  );

  dac_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .clr_code(clr_code),
    .code_wr_p(code_wr_p), .ldac_low(ldac_low), .sw_load_p(sw_load_p),
    .sw_clear_p(sw_clear_p), .sw_reset_p(sw_reset_p), .dac_code(dac_code)
  );

  always_comb begin
    ref_buf_sel  = ctrl[1];
    out_clamp    = ctrl[2];
    out_tristate = ctrl[3];
    twos_comp    = ctrl[4];
    lin_comp     = ctrl[9:6];
    miso_oe      = cs_active & ~ctrl[5];
  end

  always @(posedge clk) begin
    if (rst_n) begin
      p_lin_legal_r5: assert (lin_code_legal(lin_comp));
    end
  end

  // a software reset leaves the output parked in its safe state
  p_reset_safe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_p |-> (out_clamp && out_tristate && !miso_oe));

endmodule

// File: tb/sim_dac_serial_regif.sv
`timescale 1ns/1ps
module sim_dac_serial_regif;

  localparam int HALF = 6;
  localparam int GAP  = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, ldac_n = 1'b1;
  logic miso, miso_oe, out_clamp, out_tristate, ref_buf_sel, twos_comp;
  logic sw_reset_p, sw_clear_p, sw_load_p;
  logic [19:0] dac_code;
  logic [3:0]  lin_comp;

  always #2 clk = ~clk;

  dac_serial_regif u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .ldac_n(ldac_n), .miso(miso), .miso_oe(miso_oe), .dac_code(dac_code),
    .out_clamp(out_clamp), .out_tristate(out_tristate), .ref_buf_sel(ref_buf_sel),
    .twos_comp(twos_comp), .lin_comp(lin_comp), .sw_reset_p(sw_reset_p),
    .sw_clear_p(sw_clear_p), .sw_load_p(sw_load_p)
  );

  int n_chk = 0, n_err = 0;
  int n_load = 0, n_clear = 0, n_reset = 0;

  always @(posedge clk) begin
    if (sw_load_p)  n_load++;
    if (sw_clear_p) n_clear++;
    if (sw_reset_p) n_reset++;
  end

  // bench model
  logic [19:0] m_in = '0, m_out = '0, m_clr = '0;
  logic [9:0]  m_ctrl = 10'h00C;
  logic        m_pend = 1'b0;
  logic [2:0]  m_rsel = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic legal_lin(input logic [3:0] v);
    return (v == 4'd0) || (v == 4'd1) || (v == 4'd2) || (v == 4'd3) || (v == 4'd12);
  endfunction

  function automatic logic [9:0] model_ctrl(input logic [9:0] old, input logic [19:0] d);
    logic [3:0] lc;
    lc = legal_lin(d[9:6]) ? d[9:6] : old[9:6];
    return {lc, d[5:1], 1'b0};
  endfunction

  function automatic logic [19:0] model_read(input logic [2:0] s);
    case (s)
      3'd1: return m_in;
      3'd2: return {10'd0, m_ctrl};
      3'd3: return m_clr;
      default: return 20'd0;
    endcase
  endfunction

  task automatic xfer(input logic [23:0] tx, input int nbits,
                      output logic [23:0] rx, output logic oe_seen);
    rx = '0;
    oe_seen = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      mosi = (i < 24) ? tx[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      rx = {rx[22:0], miso};
      oe_seen = oe_seen | miso_oe;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic check_state(input string req);
    chk({req, " dac_code"}, 32'(dac_code), 32'(m_out));
    chk({req, " ctrl pins"},
        32'({lin_comp, twos_comp, out_tristate, out_clamp, ref_buf_sel}),
        32'({m_ctrl[9:6], m_ctrl[4:1]}));
  endtask

  // one frame: update model, compare readback, compare state
  task automatic frame(input logic [23:0] tx, input int nbits, input string req);
    logic [23:0] rx, exp_rx;
    logic oe, sdo_off;
    int l0, c0, r0;
    exp_rx  = m_pend ? {1'b1, m_rsel, model_read(m_rsel)} : 24'd0;
    sdo_off = m_ctrl[5];
    m_pend  = 1'b0;
    l0 = n_load; c0 = n_clear; r0 = n_reset;
    xfer(tx, nbits, rx, oe);
    if (sdo_off) chk({req, " miso_oe off"}, 32'(oe), 32'd0);
    else begin
      chk({req, " miso_oe on"}, 32'(oe), 32'd1);
      chk({req, " readback"}, 32'(rx), 32'(exp_rx));
    end
    if (nbits == 24) begin
      if (tx[23]) begin
        m_pend = 1'b1;
        m_rsel = tx[22:20];
      end else begin
        case (tx[22:20])
          3'd1: begin m_in = tx[19:0]; if (!ldac_n) m_out = tx[19:0]; end
          3'd2: m_ctrl = model_ctrl(m_ctrl, tx[19:0]);
          3'd3: m_clr = tx[19:0];
          3'd4: begin
            if (tx[2]) begin
              m_in = '0; m_out = '0; m_clr = '0; m_ctrl = 10'h00C; m_pend = 1'b0;
            end else if (tx[1]) m_out = m_clr;
            else if (tx[0]) m_out = m_in;
          end
          default: ;
        endcase
      end
    end
    // R11: strobe pulses, one clock each, only from a committed strobe write
    begin
      logic hit;
      hit = (nbits == 24) && !tx[23] && (tx[22:20] == 3'd4);
      chk("R11 load pulses",  32'(n_load - l0),  32'(hit & tx[0]));
      chk("R11 clear pulses", 32'(n_clear - c0), 32'(hit & tx[1]));
      chk("R11 reset pulses", 32'(n_reset - r0), 32'(hit & tx[2]));
    end
    check_state(req);
  endtask

  function automatic logic [23:0] wr(input logic [2:0] s, input logic [19:0] d);
    return {1'b0, s, d};
  endfunction
  function automatic logic [23:0] rd(input logic [2:0] s);
    return {1'b1, s, 20'd0};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10: reset state
    chk("R10 reset dac_code", 32'(dac_code), 32'd0);
    chk("R10 reset clamp/tristate", 32'({out_clamp, out_tristate}), 32'b11);
    chk("R10 reset other ctrl", 32'({ref_buf_sel, twos_comp, lin_comp}), 32'd0);
    chk("R6 idle miso_oe", 32'(miso_oe), 32'd0);

    // R7, R1, R3: write pending code with load high, read it back
    frame(wr(3'd1, 20'hABCDE), 24, "R7 pending only");
    frame(rd(3'd1), 24, "R3 read cmd");
    frame(wr(3'd0, 20'h0), 24, "R3 readback code");
    // R7, R11: load strobe
    frame(wr(3'd4, 20'h1), 24, "R7 load strobe");
    // R8: load pin low
    ldac_n = 1'b0;
    repeat (4) @(negedge clk);
    frame(wr(3'd1, 20'h12345), 24, "R8 direct load");
    ldac_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1, R9: clear code, clear alone and clear with load
    frame(wr(3'd3, 20'h80000), 24, "R1 clear code write");
    frame(wr(3'd1, 20'h55555), 24, "R7 pending again");
    frame(wr(3'd4, 20'h3), 24, "R9 clear beats load");
    frame(wr(3'd4, 20'h1), 24, "R7 load after clear");
    frame(wr(3'd4, 20'h2), 24, "R9 clear strobe");
    // R4, R5: control bits and compensation filter
    frame(wr(3'd2, 20'hFF31E), 24, "R4 ctrl bits lin12");
    frame(rd(3'd2), 24, "R4 read ctrl cmd");
    frame(wr(3'd0, 20'h0), 24, "R4 readback ctrl zero-ext");
    frame(wr(3'd2, 20'h00142), 24, "R5 illegal lin 5 kept");
    frame(wr(3'd2, 20'h000D2), 24, "R5 lin 3 accepted");
    frame(wr(3'd2, 20'h00356), 24, "R5 illegal lin 13 kept");
    // R2: short and long frames
    frame(wr(3'd1, 20'hFFFFF), 23, "R2 short frame");
    frame(wr(3'd2, 20'h00000), 25, "R2 long frame");
    frame(wr(3'd4, 20'h4), 23, "R2 short strobe");
    // R1: writes to unused selectors
    frame(wr(3'd0, 20'hFFFFF), 24, "R1 noop write");
    frame(wr(3'd6, 20'hFFFFF), 24, "R1 unused write");
    // R3, R11: empty selectors read zero
    frame(rd(3'd4), 24, "R11 read strobe cmd");
    frame(wr(3'd0, 20'h0), 24, "R11 strobe reads zero");
    frame(rd(3'd7), 24, "R3 read unused cmd");
    frame(rd(3'd0), 24, "R3 unused reads zero");
    frame(wr(3'd0, 20'h0), 24, "R3 noop reads zero");
    // R6: disable serial output, then re-enable
    frame(wr(3'd2, 20'h00020), 24, "R6 sdo off");
    frame(rd(3'd3), 24, "R6 read while off");
    frame(wr(3'd0, 20'h0), 24, "R6 no drive");
    frame(wr(3'd2, 20'h00000), 24, "R6 sdo on again");
    // R10: software reset
    frame(wr(3'd1, 20'h0F0F0), 24, "R10 setup");
    frame(wr(3'd4, 20'h7), 24, "R10 reset wins");
    frame(rd(3'd2), 24, "R10 read ctrl cmd");
    frame(wr(3'd0, 20'h0), 24, "R10 ctrl default");

    // random mix
    for (int k = 0; k < 110; k++) begin
      int op, nb;
      logic [19:0] d;
      d  = 20'($urandom);
      op = int'($urandom % 8);
      nb = (($urandom % 10) == 0) ? ((($urandom % 2) == 0) ? 23 : 25) : 24;
      if (($urandom % 4) == 0) begin
        ldac_n = ~ldac_n;
        repeat (4) @(negedge clk);
      end
      case (op)
        0, 1: frame(wr(3'd1, d), nb, "R1 rnd code");
        2: begin
          d[9:6] = 4'($urandom % 16);
          frame(wr(3'd2, d), nb, "R5 rnd ctrl");
        end
        3: frame(wr(3'd3, d), nb, "R1 rnd clear code");
        4: begin
          d = {17'd0, (($urandom % 5) == 0), 2'($urandom)};
          frame(wr(3'd4, d), nb, "R11 rnd strobe");
        end
        5, 6: begin
          frame(rd(3'($urandom)), 24, "R3 rnd read cmd");
          frame(wr(3'd0, 20'h0), nb, "R3 rnd readback");
        end
        default: frame(wr(3'(($urandom % 2) ? 0 : 5 + ($urandom % 3)), d), nb, "R2 rnd ignored");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule